// File: doc/BRIEF.md
# Byte-Stream Opcode Decoder for an 8-bit Processor Instruction Set

This block sits after an instruction fetch path and turns a stream of bytes, each with its own 16-bit address, into one decoded record per instruction. An input handshake (`in_valid`/`in_ready`) accepts one byte per transfer. The first byte of a record is the opcode. The block breaks it into three fields: `aaa` = bits 7:5, `bbb` = bits 4:2 and `cc` = bits 1:0. It looks up the operation and the addressing mode in a separate table for each `cc` group. It then collects zero, one or two operand bytes, depending on the mode.

When the record is complete it is presented on an output handshake (`out_valid`/`out_ready`). The record holds the opcode, an operation code, an addressing-mode code, the total length in bytes, the assembled operand and, for relative branches, the branch destination. An opcode that is not in the tables becomes a one-byte record flagged illegal, and decoding continues with the next byte. Only one record is in flight at a time: the input is stalled until the pending record is taken.

Top module: `opstream_decoder`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `out_valid` is 0 and `in_ready` is 1, and the next accepted byte is treated as an opcode.
- R2: Addressing-mode codes on `out_mode` are: 0 implied, 1 accumulator, 2 immediate, 3 zero page, 4 zero page X, 5 zero page Y, 6 absolute, 7 absolute X, 8 absolute Y, 9 zero-page X-indexed indirect, 10 zero-page indirect Y-indexed, 11 relative, 12 absolute indirect. For `cc`=01 the operation code is 8+`aaa` (the eight arithmetic/load/store ops, 8 ORA … 13 LDA … 15 SBC). The mode by `bbb` is: 000→9, 001→3, 010→2, 011→6, 100→10, 101→4, 110→8, 111→7.
- R3: For `cc`=10 with a read-modify-write, load or store operation, the operation code is 16+`aaa` (16 ASL, 19 ROR, 20 STX, 21 LDX, 23 INC). The mode by `bbb` is: 000→2, 001→3, 010→1 (accumulator, no operand byte), 011→6, 101→4, 111→7.
- R4: When `cc`=10 and `aaa` is 100 or 101 (the X-register store and load), `bbb`=101 gives mode 5 and `bbb`=111 gives mode 8 in place of the X-indexed forms.
- R5: Single-byte and control-flow ops decode as follows. For `cc`=10, `bbb`=010 with `aaa`≥100 gives codes 48–51 (48 TXA, 49 TAX, 50 DEX, 51 NOP) in mode 0, `bbb`=110 with `aaa`=100 gives 52 (TXS) and with `aaa`=101 gives 53 (TSX). For `cc`=00, `bbb`=010 gives 32+`aaa` (32 PHP) and `bbb`=110 gives 40+`aaa` (47 SED), both mode 0. Opcode 0x00 gives 1 (BRK), 0x20 gives 2 (JSR, mode 6), 0x40 gives 3 (RTI), 0x60 gives 4 (RTS), 0x4C gives 5 (JMP, mode 6) and 0x6C gives 5 in mode 12.
- R6: For `cc`=00, `aaa`=001 and `aaa`≥100 with `bbb` in {000,001,011,101,111} (except JSR) give operation code 56+`aaa` (57 BIT, 60 STY, 61 LDY, 62 CPY, 63 CPX). The mode by `bbb` is: 000→2, 001→3, 011→6, 101→4, 111→7.
- R7: `out_len` is 1 plus the operand byte count: 0 bytes for modes 0–1, 2 bytes for modes 6, 7, 8 and 12, and 1 byte otherwise. `out_operand` holds the first operand byte in bits 7:0 and the second in bits 15:8. Bits not filled by an operand byte are 0.
- R8: For `cc`=00 and `bbb`=100 the operation code is 24+`aaa` (24 BPL, 25 BMI, 30 BNE, 31 BEQ) in mode 11. `out_target` equals the opcode address + 2 + the sign-extended operand byte, modulo 2^16. In every other mode `out_target` is 0.
- R9: An opcode with `cc`=11, an unlisted `cc`=00 slot, 0x89, or a `cc`=10 opcode with `bbb`=100 or with `bbb`=110 other than TXS/TSX gives a one-byte record with `out_illegal`=1, operation 0, mode 0 and operand 0. The next byte is decoded as a new opcode.
- R10: While `out_valid` is 1 and `out_ready` is 0, every record field stays unchanged, and `in_ready` is 0 while a record is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is offered |
| in_ready | output | 1 | Block can take an input byte |
| in_byte | input | 8 | Fetched byte |
| in_addr | input | 16 | Address of the fetched byte |
| out_valid | output | 1 | Decoded record is available |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 8 | Raw opcode byte |
| out_op | output | 6 | Operation code |
| out_mode | output | 4 | Addressing-mode code |
| out_len | output | 2 | Instruction length in bytes |
| out_operand | output | 16 | Operand, first byte in the low half |
| out_target | output | 16 | Relative branch destination, else 0 |
| out_illegal | output | 1 | Opcode is not in the decode tables |

## Verification
The assertions assume that the consumer may hold `out_ready` low for any number of cycles. They also assume that `in_valid` and `in_byte` are only sampled while `in_ready` is high, so a byte offered during a pending record is simply not taken. The stimulus offers each byte and keeps it on the input until a clock edge at which `in_ready` was high. It raises `out_ready` for exactly one cycle per record, except in the backpressure scenario, where it is held low on purpose for several cycles. Byte addresses are kept consecutive, and wrap at the top of the address space only in the scenario that checks target wrap-around.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 16;
    localparam int OP_W   = 6;
    localparam int MODE_W = 4;
    localparam int LEN_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        M_IMP = 4'd0,
        M_ACC = 4'd1,
        M_IMM = 4'd2,
        M_ZP  = 4'd3,
        M_ZPX = 4'd4,
        M_ZPY = 4'd5,
        M_ABS = 4'd6,
        M_ABX = 4'd7,
        M_ABY = 4'd8,
        M_IZX = 4'd9,
        M_IZY = 4'd10,
        M_REL = 4'd11,
        M_IND = 4'd12
    } mode_e;

    localparam logic [OP_W-1:0] OPC_ILLEGAL   = 6'd0;
    localparam logic [OP_W-1:0] OPC_BRK       = 6'd1;
    localparam logic [OP_W-1:0] OPC_JSR       = 6'd2;
    localparam logic [OP_W-1:0] OPC_RTI       = 6'd3;
    localparam logic [OP_W-1:0] OPC_RTS       = 6'd4;
    localparam logic [OP_W-1:0] OPC_JMP       = 6'd5;
    localparam logic [OP_W-1:0] OPC_ALU_BASE  = 6'd8;
    localparam logic [OP_W-1:0] OPC_RMW_BASE  = 6'd16;
    localparam logic [OP_W-1:0] OPC_BR_BASE   = 6'd24;
    localparam logic [OP_W-1:0] OPC_STK_BASE  = 6'd32;
    localparam logic [OP_W-1:0] OPC_FLG_BASE  = 6'd40;
    localparam logic [OP_W-1:0] OPC_XFR_BASE  = 6'd48;
    localparam logic [OP_W-1:0] OPC_TXS       = 6'd52;
    localparam logic [OP_W-1:0] OPC_TSX       = 6'd53;
    localparam logic [OP_W-1:0] OPC_IDX_BASE  = 6'd56;

    typedef enum logic [1:0] {
        ST_OPCODE = 2'd0,
        ST_LOW    = 2'd1,
        ST_HIGH   = 2'd2,
        ST_EMIT   = 2'd3
    } fsm_e;

    function automatic logic [LEN_W-1:0] operand_bytes(input mode_e m);
        case (m)
            M_IMP, M_ACC:               operand_bytes = 2'd0;
            M_ABS, M_ABX, M_ABY, M_IND: operand_bytes = 2'd2;
            default:                    operand_bytes = 2'd1;
        endcase
    endfunction

    function automatic logic [OP_W-1:0] base_plus(input logic [OP_W-1:0] base,
                                                  input logic [2:0] idx);
        base_plus = base + {{(OP_W-3){1'b0}}, idx};
    endfunction

endpackage

// File: rtl/opdec_field_decode.sv
module opdec_field_decode
    import opdec_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode_i,
    output logic [OP_W-1:0]   op_o,
    output mode_e             mode_o,
    output logic [LEN_W-1:0]  nbytes_o,
    output logic              illegal_o
);

    logic [2:0] aaa;
    logic [2:0] bbb;
    logic [1:0] cc;
    logic       x_swap;
    logic       bad;
    logic [OP_W-1:0] op_raw;
    mode_e      mode_raw;

    assign aaa    = opcode_i[7:5];
    assign bbb    = opcode_i[4:2];
    assign cc     = opcode_i[1:0];
    assign x_swap = (aaa[2:1] == 2'b10);

    // cc=01 group mode table
    function automatic mode_e mode_g01(input logic [2:0] b);
        case (b)
            3'b000:  mode_g01 = M_IZX;
            3'b001:  mode_g01 = M_ZP;
            3'b010:  mode_g01 = M_IMM;
            3'b011:  mode_g01 = M_ABS;
            3'b100:  mode_g01 = M_IZY;
            3'b101:  mode_g01 = M_ZPX;
            3'b110:  mode_g01 = M_ABY;
            default: mode_g01 = M_ABX;
        endcase
    endfunction

    // shared table for the operand slots of cc=00 and cc=10
    function automatic mode_e mode_g00(input logic [2:0] b, input logic swap);
        case (b)
            3'b000:  mode_g00 = M_IMM;
            3'b001:  mode_g00 = M_ZP;
            3'b011:  mode_g00 = M_ABS;
            3'b101:  mode_g00 = swap ? M_ZPY : M_ZPX;
            default: mode_g00 = swap ? M_ABY : M_ABX;
        endcase
    endfunction

    always_comb begin
        op_raw   = OPC_ILLEGAL;
        mode_raw = M_IMP;
        bad      = 1'b0;
        case (cc)
            2'b01: begin
                op_raw   = base_plus(OPC_ALU_BASE, aaa);
                mode_raw = mode_g01(bbb);
                bad      = (aaa == 3'b100) && (bbb == 3'b010);
            end
            2'b10: begin
                if (bbb == 3'b010 && aaa[2]) begin
                    op_raw = base_plus(OPC_XFR_BASE, {1'b0, aaa[1:0]});
                end else if (bbb == 3'b110) begin
                    if (aaa == 3'b100)      op_raw = OPC_TXS;
                    else if (aaa == 3'b101) op_raw = OPC_TSX;
                    else                    bad    = 1'b1;
                end else if (bbb == 3'b100) begin
                    bad = 1'b1;
                end else begin
                    op_raw   = base_plus(OPC_RMW_BASE, aaa);
                    mode_raw = (bbb == 3'b010) ? M_ACC : mode_g00(bbb, x_swap);
                end
            end
            2'b00: begin
                if (bbb == 3'b100) begin
                    op_raw   = base_plus(OPC_BR_BASE, aaa);
                    mode_raw = M_REL;
                end else if (bbb == 3'b010) begin
                    op_raw = base_plus(OPC_STK_BASE, aaa);
                end else if (bbb == 3'b110) begin
                    op_raw = base_plus(OPC_FLG_BASE, aaa);
                end else begin
                    case (aaa)
                        3'b000: begin
                            if (bbb == 3'b000) op_raw = OPC_BRK;
                            else               bad    = 1'b1;
                        end
                        3'b001: begin
                            if (bbb == 3'b000) begin
                                op_raw   = OPC_JSR;
                                mode_raw = M_ABS;
                            end else begin
                                op_raw   = base_plus(OPC_IDX_BASE, aaa);
                                mode_raw = mode_g00(bbb, 1'b0);
                            end
                        end
                        3'b010: begin
                            if (bbb == 3'b000) begin
                                op_raw = OPC_RTI;
                            end else if (bbb == 3'b011) begin
                                op_raw   = OPC_JMP;
                                mode_raw = M_ABS;
                            end else begin
                                bad = 1'b1;
                            end
                        end
                        3'b011: begin
                            if (bbb == 3'b000) begin
                                op_raw = OPC_RTS;
                            end else if (bbb == 3'b011) begin
                                op_raw   = OPC_JMP;
                                mode_raw = M_IND;
                            end else begin
                                bad = 1'b1;
                            end
                        end
                        default: begin
                            op_raw   = base_plus(OPC_IDX_BASE, aaa);
                            mode_raw = mode_g00(bbb, 1'b0);
                        end
                    endcase
                end
            end
            default: bad = 1'b1;
        endcase
    end

    assign illegal_o = bad;
    assign op_o      = bad ? OPC_ILLEGAL : op_raw;
    assign mode_o    = bad ? M_IMP : mode_raw;
    assign nbytes_o  = bad ? 2'd0 : operand_bytes(mode_raw);

    always_comb begin
        if (cc == 2'b11) begin
            assert_cc11_flagged_R9: assert (illegal_o && nbytes_o == 2'd0);
        end
    end

endmodule

// File: rtl/opdec_target_calc.sv
module opdec_target_calc
    import opdec_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int OFFW = BYTE_W,
    parameter int SKIP = 2
) (
    input  logic [AW-1:0]   pc_i,
    input  logic [OFFW-1:0] offset_i,
    input  logic            is_rel_i,
    output logic [AW-1:0]   target_o
);

    localparam logic [AW-1:0] SKIP_V = AW'(SKIP);

    logic [AW-1:0] sext;
    assign sext     = {{(AW-OFFW){offset_i[OFFW-1]}}, offset_i};
    assign target_o = is_rel_i ? (pc_i + SKIP_V + sext) : '0;

endmodule

// File: rtl/opstream_decoder.sv
module opstream_decoder
    import opdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_byte,
    input  logic [15:0] in_addr,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_opcode,
    output logic [5:0]  out_op,
    output logic [3:0]  out_mode,
    output logic [1:0]  out_len,
    output logic [15:0] out_operand,
    output logic [15:0] out_target,
    output logic        out_illegal
);

    typedef struct packed {
        fsm_e              st;
        logic [BYTE_W-1:0] opcode;
        logic [ADDR_W-1:0] pc;
        logic [OP_W-1:0]   op;
        mode_e             mode;
        logic [LEN_W-1:0]  need;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic              ill;
    } rec_t;

    rec_t q, d;

    logic [OP_W-1:0]  dec_op;
    mode_e            dec_mode;
    logic [LEN_W-1:0] dec_need;
    logic             dec_ill;
    logic             take;

    opdec_field_decode u_decode (
        .opcode_i  (in_byte),
        .op_o      (dec_op),
        .mode_o    (dec_mode),
        .nbytes_o  (dec_need),
        .illegal_o (dec_ill)
    );

    opdec_target_calc #(
        .AW   (ADDR_W),
        .OFFW (BYTE_W),
        .SKIP (2)
    ) u_target (
        .pc_i     (q.pc),
        .offset_i (q.lo),
        .is_rel_i (q.mode == M_REL),
        .target_o (out_target)
    );

    assign in_ready = (q.st != ST_EMIT);
    assign take     = in_valid && in_ready;

    always_comb begin
        d = q;
        case (q.st)
            ST_OPCODE: begin
                if (take) begin
                    d.opcode = in_byte;
                    d.pc     = in_addr;
                    d.op     = dec_op;
                    d.mode   = dec_mode;
                    d.need   = dec_need;
                    d.ill    = dec_ill;
                    d.lo     = '0;
                    d.hi     = '0;
                    d.st     = (dec_need == 2'd0) ? ST_EMIT : ST_LOW;
                end
            end
            ST_LOW: begin
                if (take) begin
                    d.lo = in_byte;
                    d.st = (q.need == 2'd2) ? ST_HIGH : ST_EMIT;
                end
            end
            ST_HIGH: begin
                if (take) begin
                    d.hi = in_byte;
                    d.st = ST_EMIT;
                end
            end
            default: begin
                if (out_ready) d.st = ST_OPCODE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid   = (q.st == ST_EMIT);
    assign out_opcode  = q.opcode;
    assign out_op      = q.op;
    assign out_mode    = q.mode;
    assign out_len     = q.need + 2'd1;
    assign out_operand = {q.hi, q.lo};
    assign out_illegal = q.ill;

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    assert_hold_record_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_opcode) && $stable(out_op)
            && $stable(out_mode) && $stable(out_len) && $stable(out_operand)
            && $stable(out_target) && $stable(out_illegal)));

    assert_stall_input_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    assert_illegal_short_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_len == 2'd1 && out_op == 6'd0 && out_operand == 16'd0));

    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_len != 2'd3) |-> (out_operand[15:8] == 8'd0));

    assert_emit_after_fill_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !out_valid && q.st == ST_HIGH) |=> out_valid);

endmodule

// File: tb/opstream_decoder_tb.sv
module opstream_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = 8'h00;
    logic [15:0] in_addr = 16'h0000;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_opcode;
    logic [5:0]  out_op;
    logic [3:0]  out_mode;
    logic [1:0]  out_len;
    logic [15:0] out_operand;
    logic [15:0] out_target;
    logic        out_illegal;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [15:0] cur_addr = 16'h0200;

    always #10 clk = ~clk;

    opstream_decoder u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte), .in_addr(in_addr),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_opcode(out_opcode), .out_op(out_op), .out_mode(out_mode), .out_len(out_len),
        .out_operand(out_operand), .out_target(out_target), .out_illegal(out_illegal)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        in_addr  = cur_addr;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        cur_addr = cur_addr + 16'd1;
    endtask

    task automatic expect_rec(input string req, input logic [7:0] opc, input logic [5:0] op,
                              input logic [3:0] mode, input logic [1:0] len,
                              input logic [15:0] opnd, input logic [15:0] tgt, input logic ill);
        while (!out_valid) @(negedge clk);
        check(req, {11'd0, out_opcode, out_op, out_mode, out_len, out_operand, out_target, out_illegal},
                   {11'd0, opc, op, mode, len, opnd, tgt, ill});
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
        check("R1 in_ready after reset", {63'd0, in_ready}, 64'd1);
    endtask

    task automatic t_group01;
        put(8'hAD); put(8'h34); put(8'h12);
        expect_rec("R2 R7 LDA abs", 8'hAD, 6'd13, 4'd6, 2'd3, 16'h1234, 16'h0000, 1'b0);
        put(8'h01); put(8'h44);
        expect_rec("R2 ORA (zp,X)", 8'h01, 6'd8, 4'd9, 2'd2, 16'h0044, 16'h0000, 1'b0);
        put(8'hF9); put(8'hCD); put(8'hAB);
        expect_rec("R2 SBC abs,Y", 8'hF9, 6'd15, 4'd8, 2'd3, 16'hABCD, 16'h0000, 1'b0);
        put(8'hD1); put(8'h80);
        expect_rec("R2 CMP (zp),Y", 8'hD1, 6'd14, 4'd10, 2'd2, 16'h0080, 16'h0000, 1'b0);
    endtask

    task automatic t_group10;
        put(8'h0A);
        expect_rec("R3 R7 ASL A", 8'h0A, 6'd16, 4'd1, 2'd1, 16'h0000, 16'h0000, 1'b0);
        put(8'hFE); put(8'h00); put(8'h30);
        expect_rec("R3 INC abs,X", 8'hFE, 6'd23, 4'd7, 2'd3, 16'h3000, 16'h0000, 1'b0);
        put(8'h76); put(8'h10);
        expect_rec("R3 ROR zp,X", 8'h76, 6'd19, 4'd4, 2'd2, 16'h0010, 16'h0000, 1'b0);
    endtask

    task automatic t_swap;
        put(8'hB6); put(8'h22);
        expect_rec("R4 LDX zp,Y", 8'hB6, 6'd21, 4'd5, 2'd2, 16'h0022, 16'h0000, 1'b0);
        put(8'h96); put(8'h23);
        expect_rec("R4 STX zp,Y", 8'h96, 6'd20, 4'd5, 2'd2, 16'h0023, 16'h0000, 1'b0);
        put(8'hBE); put(8'h01); put(8'h02);
        expect_rec("R4 LDX abs,Y", 8'hBE, 6'd21, 4'd8, 2'd3, 16'h0201, 16'h0000, 1'b0);
        put(8'h16); put(8'h24);
        expect_rec("R4 ASL zp,X unswapped", 8'h16, 6'd16, 4'd4, 2'd2, 16'h0024, 16'h0000, 1'b0);
    endtask

    task automatic t_group00;
        put(8'h00);
        expect_rec("R5 BRK", 8'h00, 6'd1, 4'd0, 2'd1, 16'h0000, 16'h0000, 1'b0);
        put(8'h20); put(8'h00); put(8'hC0);
        expect_rec("R5 JSR", 8'h20, 6'd2, 4'd6, 2'd3, 16'hC000, 16'h0000, 1'b0);
        put(8'h40);
        expect_rec("R5 RTI", 8'h40, 6'd3, 4'd0, 2'd1, 16'h0000, 16'h0000, 1'b0);
        put(8'h60);
        expect_rec("R5 RTS", 8'h60, 6'd4, 4'd0, 2'd1, 16'h0000, 16'h0000, 1'b0);
        put(8'h4C); put(8'h78); put(8'h56);
        expect_rec("R5 JMP abs", 8'h4C, 6'd5, 4'd6, 2'd3, 16'h5678, 16'h0000, 1'b0);
        put(8'h6C); put(8'hFF); put(8'h02);
        expect_rec("R5 JMP ind", 8'h6C, 6'd5, 4'd12, 2'd3, 16'h02FF, 16'h0000, 1'b0);
        put(8'h08);
        expect_rec("R5 PHP", 8'h08, 6'd32, 4'd0, 2'd1, 16'h0000, 16'h0000, 1'b0);
        put(8'hF8);
        expect_rec("R5 SED", 8'hF8, 6'd47, 4'd0, 2'd1, 16'h0000, 16'h0000, 1'b0);
        put(8'h9A);
        expect_rec("R5 TXS", 8'h9A, 6'd52, 4'd0, 2'd1, 16'h0000, 16'h0000, 1'b0);
        put(8'hBA);
        expect_rec("R5 TSX", 8'hBA, 6'd53, 4'd0, 2'd1, 16'h0000, 16'h0000, 1'b0);
        put(8'hCA);
        expect_rec("R5 DEX", 8'hCA, 6'd50, 4'd0, 2'd1, 16'h0000, 16'h0000, 1'b0);
        put(8'hEA);
        expect_rec("R5 NOP", 8'hEA, 6'd51, 4'd0, 2'd1, 16'h0000, 16'h0000, 1'b0);
    endtask

    task automatic t_index00;
        put(8'h24); put(8'h05);
        expect_rec("R6 BIT zp", 8'h24, 6'd57, 4'd3, 2'd2, 16'h0005, 16'h0000, 1'b0);
        put(8'hE0); put(8'h7F);
        expect_rec("R6 CPX imm", 8'hE0, 6'd63, 4'd2, 2'd2, 16'h007F, 16'h0000, 1'b0);
        put(8'hBC); put(8'h11); put(8'h22);
        expect_rec("R6 LDY abs,X", 8'hBC, 6'd61, 4'd7, 2'd3, 16'h2211, 16'h0000, 1'b0);
    endtask

    task automatic t_branch;
        cur_addr = 16'h1000;
        put(8'hD0); put(8'h05);
        expect_rec("R8 BNE forward", 8'hD0, 6'd30, 4'd11, 2'd2, 16'h0005, 16'h1007, 1'b0);
        cur_addr = 16'h2000;
        put(8'h10); put(8'hFE);
        expect_rec("R8 BPL self", 8'h10, 6'd24, 4'd11, 2'd2, 16'h00FE, 16'h2000, 1'b0);
        cur_addr = 16'hFFF0;
        put(8'hF0); put(8'h7F);
        expect_rec("R8 BEQ wrap up", 8'hF0, 6'd31, 4'd11, 2'd2, 16'h007F, 16'h0071, 1'b0);
        cur_addr = 16'h0010;
        put(8'h30); put(8'h80);
        expect_rec("R8 BMI wrap down", 8'h30, 6'd25, 4'd11, 2'd2, 16'h0080, 16'hFF92, 1'b0);
    endtask

    task automatic t_illegal;
        cur_addr = 16'h3000;
        put(8'h03);
        expect_rec("R9 cc=11", 8'h03, 6'd0, 4'd0, 2'd1, 16'h0000, 16'h0000, 1'b1);
        put(8'hA9); put(8'h42);
        expect_rec("R9 resume after illegal", 8'hA9, 6'd13, 4'd2, 2'd2, 16'h0042, 16'h0000, 1'b0);
        put(8'h89);
        expect_rec("R9 STA imm", 8'h89, 6'd0, 4'd0, 2'd1, 16'h0000, 16'h0000, 1'b1);
        put(8'h04);
        expect_rec("R9 unlisted cc=00 a", 8'h04, 6'd0, 4'd0, 2'd1, 16'h0000, 16'h0000, 1'b1);
        put(8'h5C);
        expect_rec("R9 unlisted cc=00 b", 8'h5C, 6'd0, 4'd0, 2'd1, 16'h0000, 16'h0000, 1'b1);
        put(8'h12);
        expect_rec("R9 cc=10 bbb=100", 8'h12, 6'd0, 4'd0, 2'd1, 16'h0000, 16'h0000, 1'b1);
        put(8'h1A);
        expect_rec("R9 cc=10 bbb=110", 8'h1A, 6'd0, 4'd0, 2'd1, 16'h0000, 16'h0000, 1'b1);
    endtask

    task automatic t_backpressure;
        logic [52:0] snap;
        put(8'hA5); put(8'h99);
        while (!out_valid) @(negedge clk);
        snap = {out_opcode, out_op, out_mode, out_len, out_operand, out_target, out_illegal};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R10 record held", {11'd0, out_valid,
                  out_opcode, out_op, out_mode, out_len, out_operand, out_target, out_illegal} >> 0,
                  {11'd0, 1'b1, snap});
            check("R10 input stalled", {63'd0, in_ready}, 64'd0);
        end
        expect_rec("R10 released", 8'hA5, 6'd13, 4'd3, 2'd2, 16'h0099, 16'h0000, 1'b0);
        check("R10 ready again", {63'd0, in_ready}, 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_group01();
        t_group10();
        t_swap();
        t_group00();
        t_index00();
        t_branch();
        t_illegal();
        t_backpressure();
        put(8'hE8);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule